// File: doc/BRIEF.md
# Sensor Startup Phase Sequencer

This block decides what a sensor says on its outgoing link from power-up onwards. Each message request from the transmit scheduler yields one message word, one phase tag and one error bit, registered and valid for one cycle. The sequence always goes through power-up, identity report, self-check, an optional offset-settling period and then steady measurement output. The last of these runs until the next reset.

During the identity report the block sends the serial number one byte at a time, lowest byte first. It then sends a byte that packs the vendor and revision codes, and finally the user byte together with the extra user bit. During self-check it reports the self-test verdict. The offset-settling period already carries live acceleration samples. A failed self-test is remembered, and every measurement message after it carries the error bit.

Top module: `startup_seq`

## Requirements
- R1: After a synchronous reset, `msg_valid` is 0 and the next message is a phase-0 message with word 0 and `msg_err` 0.
- R2: Every cycle in which `msg_req` is high is followed, one clock later, by a single-cycle `msg_valid` pulse. Without a request, `msg_valid` stays 0.
- R3: Phase tags are 0 power-up, 1 identity, 2 self-check, 3 offset-settling and 4 measurement. The phases run in that order with INIT_MSGS, SN_BYTES+2, DIAG_MSGS and AZ_MSGS messages respectively. The phase never moves backwards, and phase 4 lasts until reset.
- R4: The power-up word is 0. Identity message k (k below SN_BYTES) carries serial bits [8k+7:8k] in word[7:0]. Message SN_BYTES carries {sn_written, sn_parity, rev_code[2:0], vendor_code[2:0]}, with bit 7 down to bit 0. Message SN_BYTES+1 carries user_byte. All bits not named here are 0.
- R5: user_bit9 appears as its own field in word bit 8 of the last identity message only.
- R6: When the last self-check message is sent, the block enters phase 3 if `cfg_settle_en` is 1 and skips to phase 4 if it is 0.
- R7: Every phase-3 and phase-4 word equals `accel` as sampled on the requesting cycle.
- R8: A self-check word has bit 0 = `st_fail & cfg_selftest_en` and all other bits 0.
- R9: A self-check request with `st_fail` and `cfg_selftest_en` both high sets a sticky error. `msg_err` is 1 on every later phase-4 message until reset and is 0 on all other phases.
- R10: While `cfg_selftest_en` is 0, `st_fail` has no effect on any word or on `msg_err`.
- R11: A reset in any phase returns the block to phase 0 with the message index cleared and the error cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| msg_req | input | 1 | Message request strobe from the scheduler |
| cfg_settle_en | input | 1 | Enables the offset-settling phase |
| cfg_selftest_en | input | 1 | Enables self-test evaluation |
| st_fail | input | 1 | Self-test verdict, 1 = failed |
| serial_num | input | 8*SN_BYTES | Device serial number |
| sn_written | input | 1 | Serial number programmed flag |
| sn_parity | input | 1 | Serial number parity bit |
| rev_code | input | 3 | Revision code |
| vendor_code | input | 3 | Vendor code |
| user_byte | input | 8 | User data byte |
| user_bit9 | input | 1 | Extra user bit |
| accel | input | ACC_W | Current acceleration sample |
| msg_valid | output | 1 | Message word valid |
| msg_word | output | ACC_W | Message word |
| msg_phase | output | 3 | Phase tag of the message |
| msg_err | output | 1 | Self-test error flag of the message |

## Verification
The bench builds the block with DIAG_MSGS=3 and AZ_MSGS=8, with ACC_W and SN_BYTES at their defaults. These shorter phases let each run reach measurement output well within one stimulus run. Many runs with reset in between can then cover both settling choices, passing and failing self-tests, and disabled self-test. Some runs reset in the middle of a phase to cover the return to power-up.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

    typedef enum logic [2:0] {
        PH_INIT = 3'd0,
        PH_DEV  = 3'd1,
        PH_DIAG = 3'd2,
        PH_AZ   = 3'd3,
        PH_NORM = 3'd4
    } phase_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sseq_phase_ctrl.sv
module sseq_phase_ctrl
    import sseq_pkg::*;
#(
    parameter int unsigned INIT_MSGS = 1,
    parameter int unsigned DEV_MSGS  = 6,
    parameter int unsigned DIAG_MSGS = 4,
    parameter int unsigned AZ_MSGS   = 32,
    parameter int unsigned IDX_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             az_en,
    output phase_e           phase,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST_INIT = IDX_W'(INIT_MSGS - 1);
    localparam logic [IDX_W-1:0] LAST_DEV  = IDX_W'(DEV_MSGS - 1);
    localparam logic [IDX_W-1:0] LAST_DIAG = IDX_W'(DIAG_MSGS - 1);
    localparam logic [IDX_W-1:0] LAST_AZ   = IDX_W'(AZ_MSGS - 1);

    typedef struct packed {
        phase_e           ph;
        logic [IDX_W-1:0] idx;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic [IDX_W-1:0] last_d;
    phase_e           follow_d;

    always_comb begin
        s_d      = s_q;
        last_d   = '0;
        follow_d = PH_NORM;
        case (s_q.ph)
            PH_INIT: begin last_d = LAST_INIT; follow_d = PH_DEV;  end
            PH_DEV:  begin last_d = LAST_DEV;  follow_d = PH_DIAG; end
            PH_DIAG: begin last_d = LAST_DIAG; follow_d = az_en ? PH_AZ : PH_NORM; end
            PH_AZ:   begin last_d = LAST_AZ;   follow_d = PH_NORM; end
            default: begin last_d = '0;        follow_d = PH_NORM; end
        endcase
        if (step && s_q.ph != PH_NORM) begin
            if (s_q.idx == last_d) begin
                s_d.ph  = follow_d;
                s_d.idx = '0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{ph: PH_INIT, idx: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase = s_q.ph;
    assign idx   = s_q.idx;

endmodule

// File: rtl/sseq_msg_mux.sv
module sseq_msg_mux
    import sseq_pkg::*;
#(
    parameter int unsigned ACC_W    = 10,
    parameter int unsigned SN_BYTES = 4,
    parameter int unsigned IDX_W    = 5
) (
    input  phase_e                 phase,
    input  logic [IDX_W-1:0]       idx,
    input  logic [8*SN_BYTES-1:0]  serial_num,
    input  logic                   sn_written,
    input  logic                   sn_parity,
    input  logic [2:0]             rev_code,
    input  logic [2:0]             vendor_code,
    input  logic [7:0]             user_byte,
    input  logic                   user_bit9,
    input  logic [ACC_W-1:0]       accel,
    input  logic                   st_fail,
    input  logic                   st_en,
    output logic [ACC_W-1:0]       word
);

    localparam logic [IDX_W-1:0] ID_SLOT   = IDX_W'(SN_BYTES);
    localparam logic [IDX_W-1:0] USER_SLOT = IDX_W'(SN_BYTES + 1);

    logic [7:0] sn_byte [SN_BYTES];

    for (genvar b = 0; b < SN_BYTES; b++) begin : g_sn
        assign sn_byte[b] = serial_num[8*b +: 8];
    end

    always_comb begin
        word = '0;
        case (phase)
            PH_DEV: begin
                for (int b = 0; b < SN_BYTES; b++) begin
                    if (idx == IDX_W'(b)) word[7:0] = sn_byte[b];
                end
                if (idx == ID_SLOT) begin
                    word[7:0] = {sn_written, sn_parity, rev_code, vendor_code};
                end
                if (idx == USER_SLOT) begin
                    word[7:0] = user_byte;
                    word[8]   = user_bit9;
                end
            end
            PH_DIAG: word[0] = st_fail & st_en;
            PH_AZ, PH_NORM: word = accel;
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/sseq_err_track.sv
module sseq_err_track (
    input  logic clk,
    input  logic rst,
    input  logic set,
    output logic err
);

    logic err_d, err_q;

    always_comb begin
        err_d = err_q | set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import sseq_pkg::*;
#(
    parameter int unsigned ACC_W     = 10,
    parameter int unsigned SN_BYTES  = 4,
    parameter int unsigned INIT_MSGS = 1,
    parameter int unsigned DIAG_MSGS = 4,
    parameter int unsigned AZ_MSGS   = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  msg_req,
    input  logic                  cfg_settle_en,
    input  logic                  cfg_selftest_en,
    input  logic                  st_fail,
    input  logic [8*SN_BYTES-1:0] serial_num,
    input  logic                  sn_written,
    input  logic                  sn_parity,
    input  logic [2:0]            rev_code,
    input  logic [2:0]            vendor_code,
    input  logic [7:0]            user_byte,
    input  logic                  user_bit9,
    input  logic [ACC_W-1:0]      accel,
    output logic                  msg_valid,
    output logic [ACC_W-1:0]      msg_word,
    output logic [2:0]            msg_phase,
    output logic                  msg_err
);

    localparam int unsigned DEV_MSGS = SN_BYTES + 2;
    localparam int unsigned MAX_MSGS =
        max_of(max_of(max_of(INIT_MSGS, DEV_MSGS), max_of(DIAG_MSGS, AZ_MSGS)), 2);
    localparam int unsigned IDX_W = $clog2(MAX_MSGS);

    typedef struct packed {
        logic             valid;
        phase_e           ph;
        logic [ACC_W-1:0] word;
        logic             err;
    } out_t;

    phase_e           cur_phase;
    logic [IDX_W-1:0] cur_idx;
    logic [ACC_W-1:0] mux_word;
    logic             err_flag;
    logic             err_set;
    out_t             o_d, o_q;

    sseq_phase_ctrl #(
        .INIT_MSGS(INIT_MSGS), .DEV_MSGS(DEV_MSGS), .DIAG_MSGS(DIAG_MSGS),
        .AZ_MSGS(AZ_MSGS), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .step(msg_req), .az_en(cfg_settle_en),
        .phase(cur_phase), .idx(cur_idx)
    );

    sseq_msg_mux #(
        .ACC_W(ACC_W), .SN_BYTES(SN_BYTES), .IDX_W(IDX_W)
    ) u_mux (
        .phase(cur_phase), .idx(cur_idx), .serial_num(serial_num),
        .sn_written(sn_written), .sn_parity(sn_parity), .rev_code(rev_code),
        .vendor_code(vendor_code), .user_byte(user_byte), .user_bit9(user_bit9),
        .accel(accel), .st_fail(st_fail), .st_en(cfg_selftest_en), .word(mux_word)
    );

    assign err_set = msg_req && cur_phase == PH_DIAG && cfg_selftest_en && st_fail;

    sseq_err_track u_err (
        .clk(clk), .rst(rst), .set(err_set), .err(err_flag)
    );

    always_comb begin
        o_d       = o_q;
        o_d.valid = msg_req;
        if (msg_req) begin
            o_d.ph   = cur_phase;
            o_d.word = mux_word;
            o_d.err  = (cur_phase == PH_NORM) && err_flag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '{valid: 1'b0, ph: PH_INIT, word: '0, err: 1'b0};
        end else begin
            o_q <= o_d;
        end
    end

    assign msg_valid = o_q.valid;
    assign msg_word  = o_q.word;
    assign msg_phase = o_q.ph;
    assign msg_err   = o_q.err;

endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk
    import sseq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       msg_req,
    input logic       cfg_settle_en,
    input logic [2:0] cur_phase,
    input logic       err_flag,
    input logic       msg_valid,
    input logic [2:0] msg_phase,
    input logic       msg_err
);

    localparam logic [2:0] P_DIAG = 3'(PH_DIAG);
    localparam logic [2:0] P_AZ   = 3'(PH_AZ);
    localparam logic [2:0] P_NORM = 3'(PH_NORM);

    assert_valid_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> $past(msg_req));

    assert_req_gives_valid_R2: assert property (@(posedge clk) disable iff (rst)
        msg_req |=> msg_valid);

    assert_phase_forward_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cur_phase >= $past(cur_phase));

    assert_phase_legal_R3: assert property (@(posedge clk) disable iff (rst)
        cur_phase <= P_NORM);

    assert_settle_choice_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cur_phase) == P_DIAG && cur_phase != P_DIAG)
        |-> cur_phase == ($past(cfg_settle_en) ? P_AZ : P_NORM));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(err_flag)) |-> err_flag);

    assert_err_norm_only_R9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_err) |-> msg_phase == P_NORM);

endmodule

bind startup_seq startup_seq_chk u_chk (
    .clk(clk), .rst(rst), .msg_req(msg_req), .cfg_settle_en(cfg_settle_en),
    .cur_phase(cur_phase), .err_flag(err_flag), .msg_valid(msg_valid),
    .msg_phase(msg_phase), .msg_err(msg_err)
);

// File: tb/startup_seq_test.sv
module startup_seq_test;

    localparam int ACC_W    = 10;
    localparam int SN_BYTES = 4;
    localparam int INIT_M   = 1;
    localparam int DEV_M    = SN_BYTES + 2;
    localparam int DIAG_M   = 3;
    localparam int AZ_M     = 8;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  msg_req = 1'b0;
    logic                  cfg_settle_en = 1'b0;
    logic                  cfg_selftest_en = 1'b0;
    logic                  st_fail = 1'b0;
    logic [8*SN_BYTES-1:0] serial_num = '0;
    logic                  sn_written = 1'b0;
    logic                  sn_parity = 1'b0;
    logic [2:0]            rev_code = '0;
    logic [2:0]            vendor_code = '0;
    logic [7:0]            user_byte = '0;
    logic                  user_bit9 = 1'b0;
    logic [ACC_W-1:0]      accel = '0;
    logic                  msg_valid;
    logic [ACC_W-1:0]      msg_word;
    logic [2:0]            msg_phase;
    logic                  msg_err;

    int checks = 0;
    int errors = 0;
    int m_ph, m_idx;
    bit m_err;
    string first_tag = "";

    always #2 clk = ~clk;

    startup_seq #(
        .ACC_W(ACC_W), .SN_BYTES(SN_BYTES), .INIT_MSGS(INIT_M),
        .DIAG_MSGS(DIAG_M), .AZ_MSGS(AZ_M)
    ) uut (
        .clk(clk), .rst(rst), .msg_req(msg_req), .cfg_settle_en(cfg_settle_en),
        .cfg_selftest_en(cfg_selftest_en), .st_fail(st_fail), .serial_num(serial_num),
        .sn_written(sn_written), .sn_parity(sn_parity), .rev_code(rev_code),
        .vendor_code(vendor_code), .user_byte(user_byte), .user_bit9(user_bit9),
        .accel(accel), .msg_valid(msg_valid), .msg_word(msg_word),
        .msg_phase(msg_phase), .msg_err(msg_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int phase_len(input int ph);
        case (ph)
            0: return INIT_M;
            1: return DEV_M;
            2: return DIAG_M;
            3: return AZ_M;
            default: return 0;
        endcase
    endfunction

    function automatic logic [ACC_W-1:0] exp_word(input int ph, input int idx);
        logic [ACC_W-1:0] w = '0;
        case (ph)
            1: begin
                if (idx < SN_BYTES) w[7:0] = serial_num[8*idx +: 8];
                else if (idx == SN_BYTES)
                    w[7:0] = {sn_written, sn_parity, rev_code, vendor_code};
                else begin w[7:0] = user_byte; w[8] = user_bit9; end
            end
            2: w[0] = st_fail & cfg_selftest_en;
            3, 4: w = accel;
            default: w = '0;
        endcase
        return w;
    endfunction

    function automatic string word_tag(input int ph, input int idx);
        case (ph)
            0: return "R4 power-up word";
            1: return (idx == SN_BYTES + 1) ? "R5 user bit field" : "R4 identity word";
            2: return cfg_selftest_en ? "R8 self-check word" : "R10 self-check word";
            default: return "R7 sample word";
        endcase
    endfunction

    task automatic model_reset();
        m_ph = 0; m_idx = 0; m_err = 1'b0;
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1; msg_req = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check({tag, " valid low after reset"}, 32'(msg_valid), 32'd0);
        check({tag, " err low after reset"}, 32'(msg_err), 32'd0);
        first_tag = tag;
    endtask

    task automatic cycle(input bit req, input int fail_pct);
        int ph_now, idx_now;
        logic [ACC_W-1:0] w_exp;
        bit err_exp;
        string wt;
        msg_req = req;
        accel   = ACC_W'($urandom);
        st_fail = ($urandom % 100) < fail_pct;
        ph_now  = m_ph;
        idx_now = m_idx;
        w_exp   = exp_word(ph_now, idx_now);
        wt      = word_tag(ph_now, idx_now);
        err_exp = (ph_now == 4) && m_err;
        @(posedge clk);
        @(negedge clk);
        if (!req) begin
            check("R2 no request no valid", 32'(msg_valid), 32'd0);
        end else begin
            check("R2 valid after request", 32'(msg_valid), 32'd1);
            if (first_tag != "") begin
                check({first_tag, " first phase after reset"}, 32'(msg_phase), 32'd0);
                first_tag = "";
            end
            check((ph_now == 3 || (ph_now == 4 && idx_now == 0)) ? "R6 phase tag" : "R3 phase tag",
                  32'(msg_phase), 32'(ph_now));
            check(wt, 32'(msg_word), 32'(w_exp));
            check(cfg_selftest_en ? "R9 error bit" : "R10 error bit", 32'(msg_err), 32'(err_exp));
            if (ph_now == 2 && cfg_selftest_en && st_fail) m_err = 1'b1;
            if (ph_now != 4) begin
                if (m_idx == phase_len(m_ph) - 1) begin
                    m_idx = 0;
                    if (m_ph == 2) m_ph = cfg_settle_en ? 3 : 4;
                    else m_ph = m_ph + 1;
                end else begin
                    m_idx++;
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int run = 0; run < 30; run++) begin
            int fail_pct;
            serial_num  = 32'($urandom);
            sn_written  = 1'($urandom);
            sn_parity   = 1'($urandom);
            rev_code    = 3'($urandom);
            vendor_code = 3'($urandom);
            user_byte   = 8'($urandom);
            user_bit9   = 1'($urandom);
            cfg_settle_en   = 1'($urandom);
            cfg_selftest_en = 1'($urandom);
            fail_pct = 20;
            if (run == 0) begin cfg_settle_en = 1'b1; cfg_selftest_en = 1'b1; fail_pct = 0;   end
            if (run == 1) begin cfg_settle_en = 1'b0; cfg_selftest_en = 1'b1; fail_pct = 100; end
            if (run == 2) begin cfg_settle_en = 1'b1; cfg_selftest_en = 1'b0; fail_pct = 100; end
            if (run == 3) begin serial_num = 32'hA55A_0FF0; user_bit9 = 1'b1; user_byte = 8'hFF; end
            do_reset("R1");
            for (int c = 0; c < 60; c++) begin
                if (run % 5 == 4 && c == 12) do_reset("R11");
                cycle(($urandom % 4) != 0, fail_pct);
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule